// File: doc/BRIEF.md
# Clock Output Release Sequencer

This block decides when the clock outputs of a frequency synthesizer may toggle. A free-running timing clock drives it. It takes a power-on reset and an active-low shutdown request, and it produces three control levels. The first asks the loop circuits to power down. The second lets the crystal oscillator start. The third is an output-enable that keeps every clock output low while it is deasserted. The oscillator, the loops and the output gating belong to other blocks; this one only produces their enables.

After power-up, and again each time shutdown is released, the sequencer waits a fixed hold-off of `HOLD_CYCLES` timing-clock cycles before it enables the outputs, so the loops can settle first. The default corresponds to 256 ms at a 50 MHz timing clock. The oscillator is held off until the first hold-off interval has completed, and from then on it is left running. The shutdown input is asynchronous and passes through a two-flop synchronizer. If shutdown is reasserted while a hold-off is running, the interval is abandoned, and the next release starts the interval again from zero.

Top module: `clk_release_seq`

## Requirements
- R1: While the power-on reset `rstN` is low, `outEnable` is 0, `oscStartEn` is 0 and `loopPowerDown` is 1.
- R2: `stopN` passes through two synchronizing flops. After `stopN` rises (or after reset is released with `stopN` high), `loopPowerDown` falls at the 3rd rising clock edge.
- R3: After a release, `outEnable` rises at rising edge 3 + `HOLD_CYCLES`, counted from the release, provided shutdown is not reasserted in the meantime.
- R4: `oscStartEn` stays 0 until the first hold-off interval completes. It rises at the same edge as the first rise of `outEnable`, and it stays 1 through every later shutdown until the next power-on reset.
- R5: When `stopN` falls, `outEnable` is 0 and `loopPowerDown` is 1 from the 3rd rising clock edge after the fall onward.
- R6: If `stopN` falls k clock cycles after a release, with 1 <= k <= `HOLD_CYCLES`, `outEnable` never rises. The next release again waits the full 3 + `HOLD_CYCLES` edges.
- R7: `outEnable` rises at most once for each release, and it is never 1 while `loopPowerDown` is 1.
- R8: If `stopN` is held low across the release of reset, `outEnable` and `oscStartEn` stay 0 and `loopPowerDown` stays 1 for as long as `stopN` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timing clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| stopN | input | 1 | Asynchronous shutdown request, active low |
| loopPowerDown | output | 1 | Power-down request to both loops (1 = powered down) |
| oscStartEn | output | 1 | Crystal oscillator start enable |
| outEnable | output | 1 | Clock output enable (0 = all outputs forced low) |

## Verification
The bench sweeps the instant at which shutdown is reasserted across the whole hold-off, one cycle at a time.
- If the abort were handled wrongly, the outputs would leak an enable near the end of the interval.
- If the counter were not cleared on an abort, the following release would come back early.

The sweep continues one cycle past the end of the interval. There the bench expects exactly one cycle of enable, which exposes an off-by-one in the terminal count or in the synchronizer depth. Separate runs check the following:
- The oscillator enable must not drop again after a later shutdown.
- With shutdown held through reset, nothing may be enabled at all.

// File: rtl/clk_release_pkg.sv
package clk_release_pkg;

  typedef enum logic [1:0] {
    ST_SHUT = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic cntClear;
    logic cntStep;
  } timerCmd_t;

endpackage

// File: rtl/holdoff_path.sv
module holdoff_path
  import clk_release_pkg::*;
#(
  parameter int HOLD_CYCLES = 12_800_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      stopNAsync,
  input  timerCmd_t cmd,
  output logic      stopSync,
  output logic      cntDone
);

  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [CNT_W-1:0]       holdCnt;

  // Synchronizer; resets to the shutdown level so the outputs start out safe.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], stopNAsync};
  end

  assign stopSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             holdCnt <= '0;
    else if (cmd.cntClear) holdCnt <= '0;
    else if (cmd.cntStep)  holdCnt <= holdCnt + 1'b1;
  end

  assign cntDone = (holdCnt == CNT_LAST);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= CNT_LAST);

  // R6
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.cntClear |=> (holdCnt == '0));

endmodule

// File: rtl/release_ctrl.sv
module release_ctrl
  import clk_release_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stopSync,
  input  logic      cntDone,
  output timerCmd_t cmd,
  output logic      loopPowerDown,
  output logic      oscStartEn,
  output logic      outEnable
);

  seqState_t state, stateNext;
  logic      oscStarted;

  always_comb begin
    stateNext = state;
    case (state)
      ST_SHUT: if (stopSync) stateNext = ST_HOLD;
      ST_HOLD: begin
        if (!stopSync)    stateNext = ST_SHUT;
        else if (cntDone) stateNext = ST_RUN;
      end
      ST_RUN:  if (!stopSync) stateNext = ST_SHUT;
      default: stateNext = ST_SHUT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SHUT;
    else       state <= stateNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        oscStarted <= 1'b0;
    else if (state == ST_HOLD && stopSync && cntDone) oscStarted <= 1'b1;
  end

  always_comb begin
    cmd.cntClear = (state != ST_HOLD);
    cmd.cntStep  = (state == ST_HOLD) && !cntDone;
  end

  assign loopPowerDown = (state == ST_SHUT);
  assign outEnable     = (state == ST_RUN);
  assign oscStartEn    = oscStarted;

  // R4
  osc_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    oscStartEn |=> oscStartEn);

  // R4
  osc_before_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEnable |-> oscStartEn);

  // R7
  out_vs_pd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(outEnable && loopPowerDown));

  // R3
  out_rise_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outEnable) |-> $past(cntDone && stopSync));

  // R5
  stop_forces_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stopSync |=> !outEnable);

endmodule

// File: rtl/clk_release_seq.sv
module clk_release_seq
  import clk_release_pkg::*;
#(
  parameter int HOLD_CYCLES = 12_800_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic stopN,
  output logic loopPowerDown,
  output logic oscStartEn,
  output logic outEnable
);

  timerCmd_t timerCmd;
  logic      stopSync;
  logic      cntDone;

  holdoff_path #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .SYNC_STAGES (2)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .stopNAsync (stopN),
    .cmd        (timerCmd),
    .stopSync   (stopSync),
    .cntDone    (cntDone)
  );

  release_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .stopSync      (stopSync),
    .cntDone       (cntDone),
    .cmd           (timerCmd),
    .loopPowerDown (loopPowerDown),
    .oscStartEn    (oscStartEn),
    .outEnable     (outEnable)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!outEnable && !oscStartEn && loopPowerDown));

endmodule

// File: tb/clk_release_seq_bench.sv
module clk_release_seq_bench;

  localparam int H = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopN = 1'b1;
  logic loopPowerDown, oscStartEn, outEnable;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clk_release_seq #(.HOLD_CYCLES(H)) u_clk_release_seq (
    .clk           (clk),
    .rstN          (rstN),
    .stopN         (stopN),
    .loopPowerDown (loopPowerDown),
    .oscStartEn    (oscStartEn),
    .outEnable     (outEnable)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs span cycles from the current negedge. If dropAt > 0, stopN is pulled
  // low just after edge dropAt. Reports the first edge of each event.
  task automatic episode(input int dropAt, input int span,
                         output int pdLowAt, output int oenAt, output int oscAt,
                         output int rises, output int highCnt, output int clash);
    logic prevOen;
    pdLowAt = -1; oenAt = -1; oscAt = -1; rises = 0; highCnt = 0; clash = 0;
    prevOen = outEnable;
    for (int i = 1; i <= span; i++) begin
      @(posedge clk); @(negedge clk);
      if (!loopPowerDown && pdLowAt < 0) pdLowAt = i;
      if (outEnable && oenAt < 0) oenAt = i;
      if (oscStartEn && oscAt < 0) oscAt = i;
      if (outEnable && !prevOen) rises++;
      if (outEnable) highCnt++;
      if (outEnable && loopPowerDown) clash++;
      prevOen = outEnable;
      if (i == dropAt) stopN = 1'b0;
    end
  endtask

  task automatic shutDown(output int pdAt, output int oenOffAt);
    pdAt = -1; oenOffAt = -1;
    stopN = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      @(posedge clk); @(negedge clk);
      if (loopPowerDown && pdAt < 0) pdAt = i;
      if (!outEnable && oenOffAt < 0) oenOffAt = i;
    end
  endtask

  task automatic fullRelease(input string tag);
    int pd, oe, osc, ri, hc, cl;
    stopN = 1'b1;
    episode(0, H + 6, pd, oe, osc, ri, hc, cl);
    check({tag, " R2 pd low edge"}, pd, 3);
    check({tag, " R3 oen edge"}, oe, 3 + H);
    check({tag, " R7 rises"}, ri, 1);
    check({tag, " R7 clash"}, cl, 0);
  endtask

  initial begin
    int pd, oe, osc, ri, hc, cl, pdAt, offAt;

    // R1: reset state
    rstN = 1'b0; stopN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 outEnable in reset", outEnable, 0);
    check("R1 oscStartEn in reset", oscStartEn, 0);
    check("R1 loopPowerDown in reset", loopPowerDown, 1);

    // Power-up release with stopN already high
    rstN = 1'b1;
    episode(0, H + 6, pd, oe, osc, ri, hc, cl);
    check("R2 power-up pd low edge", pd, 3);
    check("R3 power-up oen edge", oe, 3 + H);
    check("R4 power-up osc edge", osc, 3 + H);
    check("R7 power-up rises", ri, 1);

    // R5: shutdown
    shutDown(pdAt, offAt);
    check("R5 pd edge", pdAt, 3);
    check("R5 oen off edge", offAt, 3);
    check("R4 osc held in shutdown", oscStartEn, 1);

    fullRelease("plain");

    // R6: abort sweep across the hold-off, plus one cycle beyond
    for (int k = 1; k <= H + 1; k++) begin
      shutDown(pdAt, offAt);
      stopN = 1'b1;
      episode(k, H + 8, pd, oe, osc, ri, hc, cl);
      check($sformatf("R6 abort k=%0d pd low", k), pd, 3);
      if (k <= H) begin
        check($sformatf("R6 abort k=%0d oen", k), oe, -1);
      end else begin
        check($sformatf("R6 late k=%0d oen edge", k), oe, 3 + H);
        check($sformatf("R7 late k=%0d high cycles", k), hc, 1);
      end
      check($sformatf("R5 abort k=%0d pd at end", k), loopPowerDown, 1);
      check($sformatf("R4 abort k=%0d osc", k), oscStartEn, 1);
      fullRelease($sformatf("after k=%0d", k));
    end

    // R8: shutdown held across reset release
    rstN = 1'b0; stopN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    episode(0, H + 20, pd, oe, osc, ri, hc, cl);
    check("R8 oen stays low", oe, -1);
    check("R8 osc stays low", osc, -1);
    check("R8 pd never low", pd, -1);
    stopN = 1'b1;
    episode(0, H + 6, pd, oe, osc, ri, hc, cl);
    check("R8 late release oen edge", oe, 3 + H);
    check("R4 late release osc edge", osc, 3 + H);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100_000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule